// File: doc/BRIEF.md
# Vertical Microcode Sequencer

This block is a microprogrammed control unit built around a 64-entry store of 10-bit microwords and a 6-bit microprogram counter. Every microword takes one of two shapes. A transfer word carries a 9-bit encoded operation. The sequencer hands that operation to a decoder outside the block for one cycle and then moves to the following address. A branch word tests one of four condition inputs against a bit held in the word. It either jumps to a 6-bit target or moves to the following address, and it emits no operation.

The store contents come from a parameter image, so one netlist can run any microprogram. The store is read synchronously, and the read address is the next program-counter value, which lets an FPGA map the store onto block RAM. The condition inputs are the memory wait flag, the accumulator sign and the two top instruction-register bits. The block does not turn operations into datapath strobes.

Top module: `vms_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `upc` = 0, `uop_valid` = 0 and `uop_code` = 0. The first word executed after reset is the one at address 0.
- R2: Bit 9 of a microword selects its format. When it is 0 (transfer word), the edge that executes the word sets `uop_valid` = 1 and `uop_code` = word[8:0] for that one cycle, and advances `upc` by one.
- R3: A branch word (bit 9 = 1) produces `uop_valid` = 0 in the following cycle. Whenever `uop_valid` is 0, `uop_code` is 0.
- R4: In a branch word, bits [8:7] select the condition, bit 6 is the compare value and bits [5:0] are the target. When the selected condition equals the compare value, `upc` becomes the target.
- R5: The condition select encodes 00 as `wait_in`, 01 as `ac_sign`, 10 as `ir_op[1]` (instruction bit 15) and 11 as `ir_op[0]` (instruction bit 14). The unselected inputs have no effect.
- R6: When the selected condition differs from the compare value, `upc` advances by one.
- R7: Falling through from address 63 wraps `upc` to 0.
- R8: Condition inputs are sampled only at the edge that executes a branch word. Their values at edges that execute transfer words have no effect on `upc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wait_in | input | 1 | Memory wait condition (select 00) |
| ac_sign | input | 1 | Accumulator sign condition (select 01) |
| ir_op | input | 2 | Instruction bits 15 ([1], select 10) and 14 ([0], select 11) |
| uop_valid | output | 1 | Registered strobe: a transfer word executed at the last edge |
| uop_code | output | 9 | Registered encoded operation, zero when not valid |
| upc | output | 6 | Address of the microword executed at the next edge |

## Verification
Two cases are hardest to reach from the ports. One is a branch whose condition has to be told apart from the other three inputs. The other is the wrap from address 63. The bench loads its own microprogram image. In that image each condition select is tested once with its selected input against the compare value and all the unselected inputs set the opposite way, and a chain of taken branches lands on address 60 so that the program runs through to the top of the store. The bench also changes condition inputs while transfer words execute, to show that those edges ignore them.

// File: rtl/vms_pkg.sv
package vms_pkg;
  localparam int ADDR_W = 6;
  localparam int OP_W   = 9;
  localparam int WORD_W = OP_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SEL_W  = 2;
  localparam int NCOND  = 1 << SEL_W;

  typedef logic [ADDR_W-1:0]             addr_t;
  typedef logic [OP_W-1:0]               op_t;
  typedef logic [WORD_W-1:0]             uword_t;
  typedef logic [DEPTH-1:0][WORD_W-1:0]  image_t;

  // Field positions inside a microword
  localparam int FMT_BIT = WORD_W - 1;
  localparam int SEL_HI  = FMT_BIT - 1;
  localparam int SEL_LO  = FMT_BIT - SEL_W;
  localparam int CMP_BIT = SEL_LO - 1;

  // Default image: every word is a transfer carrying its own address.
  function automatic image_t default_image();
    image_t img;
    for (int i = 0; i < DEPTH; i++) begin
      img[i] = uword_t'(i);
    end
    return img;
  endfunction
endpackage

// File: rtl/vms_store.sv
module vms_store
  import vms_pkg::*;
#(
  parameter image_t IMAGE = default_image()
) (
  input  logic   clk,
  input  addr_t  rd_addr,
  output uword_t rd_word
);
  uword_t mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = IMAGE[i];
    end
  end

  always_ff @(posedge clk) begin
    rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/vms_cond_mux.sv
module vms_cond_mux
  import vms_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             wait_in,
  input  logic             ac_sign,
  input  logic [1:0]       ir_op,
  output logic             cond
);
  logic [NCOND-1:0] src;

  assign src[0] = wait_in;
  assign src[1] = ac_sign;
  assign src[2] = ir_op[1];
  assign src[3] = ir_op[0];

  always_comb begin
    cond = src[sel];
  end
endmodule

// File: rtl/vms_next_addr.sv
module vms_next_addr
  import vms_pkg::*;
(
  input  uword_t word,
  input  addr_t  pc,
  input  logic   cond,
  output addr_t  next_pc,
  output logic   is_xfer
);
  addr_t seq_pc;
  logic  take;

  always_comb begin
    seq_pc  = addr_t'(pc + 1'b1);
    is_xfer = ~word[FMT_BIT];
    take    = word[FMT_BIT] & (cond == word[CMP_BIT]);
    next_pc = take ? word[ADDR_W-1:0] : seq_pc;
  end
endmodule

// File: rtl/vms_sequencer.sv
module vms_sequencer
  import vms_pkg::*;
#(
  parameter image_t PROGRAM = default_image()
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wait_in,
  input  logic            ac_sign,
  input  logic [1:0]      ir_op,
  output logic            uop_valid,
  output logic [OP_W-1:0] uop_code,
  output logic [ADDR_W-1:0] upc
);
  addr_t  pc_q;
  addr_t  pc_d;
  addr_t  rd_addr;
  uword_t word_q;
  logic   cond;
  logic   is_xfer;

  vms_cond_mux u_cond (
    .sel     (word_q[SEL_HI:SEL_LO]),
    .wait_in (wait_in),
    .ac_sign (ac_sign),
    .ir_op   (ir_op),
    .cond    (cond)
  );

  vms_next_addr u_next (
    .word    (word_q),
    .pc      (pc_q),
    .cond    (cond),
    .next_pc (pc_d),
    .is_xfer (is_xfer)
  );

  assign rd_addr = rst ? '0 : pc_d;

  vms_store #(.IMAGE(PROGRAM)) u_store (
    .clk     (clk),
    .rd_addr (rd_addr),
    .rd_word (word_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      uop_valid <= 1'b0;
      uop_code  <= '0;
    end else begin
      pc_q      <= pc_d;
      uop_valid <= is_xfer;
      uop_code  <= is_xfer ? word_q[OP_W-1:0] : '0;
    end
  end

  assign upc = pc_q;
endmodule

// File: rtl/vms_sequencer_chk.sv
module vms_sequencer_chk
  import vms_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input addr_t  upc,
  input logic   uop_valid,
  input op_t    uop_code,
  input uword_t cur_word
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (upc == '0 && !uop_valid && uop_code == '0));

  // R2
  xfer_advance_chk: assert property (@(posedge clk) disable iff (rst)
    uop_valid |-> upc == addr_t'($past(upc) + 1'b1));

  // R3
  branch_silent_chk: assert property (@(posedge clk) disable iff (rst)
    cur_word[FMT_BIT] |=> !uop_valid);

  // R3
  idle_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !uop_valid |-> uop_code == '0);

  // R4 R6
  branch_dest_chk: assert property (@(posedge clk) disable iff (rst)
    cur_word[FMT_BIT] |=> (upc == $past(cur_word[ADDR_W-1:0]) ||
                           upc == addr_t'($past(upc) + 1'b1)));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!cur_word[FMT_BIT] && upc == addr_t'(DEPTH - 1)) |=> upc == '0);
endmodule

bind vms_sequencer vms_sequencer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .upc       (upc),
  .uop_valid (uop_valid),
  .uop_code  (uop_code),
  .cur_word  (word_q)
);

// File: tb/vms_sequencer_test.sv
`timescale 1ns/1ps
module vms_sequencer_test;
  import vms_pkg::*;

  function automatic uword_t xfer(input int code);
    return {1'b0, op_t'(code)};
  endfunction

  function automatic uword_t br(input int sel, input int cmp, input int tgt);
    return {1'b1, 2'(sel), 1'(cmp), addr_t'(tgt)};
  endfunction

  function automatic image_t bench_image();
    image_t img;
    for (int i = 0; i < DEPTH; i++) img[i] = xfer(9'h100 | i);
    img[0]  = xfer(9'h0A5);
    img[1]  = xfer(9'h15A);
    img[2]  = br(0, 1, 2);   // spin while wait_in = 1
    img[3]  = xfer(9'h111);
    img[4]  = br(1, 1, 8);   // ac_sign = 1 -> 8
    img[5]  = xfer(9'h055);
    img[6]  = br(2, 0, 10);  // ir_op[1] = 0 -> 10
    img[7]  = xfer(9'h077);
    img[8]  = xfer(9'h088);
    img[9]  = br(3, 1, 60);  // ir_op[0] = 1 -> 60
    img[10] = xfer(9'h0AA);
    img[11] = br(0, 0, 0);   // wait_in = 0 -> 0
    return img;
  endfunction

  localparam image_t PROG = bench_image();

  // {wait, ac, ir15, ir14, expected upc, expected valid, expected code}
  localparam int NV = 35;
  localparam logic [19:0] VEC [NV] = '{
    {4'b0000, 6'd1,  1'b1, 9'h0A5},  // 0  R2
    {4'b0000, 6'd2,  1'b1, 9'h15A},  // 1  R2
    {4'b1000, 6'd2,  1'b0, 9'h000},  // 2  R4 taken wait
    {4'b1000, 6'd2,  1'b0, 9'h000},  // 3  R4
    {4'b0000, 6'd3,  1'b0, 9'h000},  // 4  R6
    {4'b1000, 6'd4,  1'b1, 9'h111},  // 5  R8 ignored
    {4'b0000, 6'd5,  1'b0, 9'h000},  // 6  R6 ac=0
    {4'b0100, 6'd6,  1'b1, 9'h055},  // 7  R8
    {4'b0010, 6'd7,  1'b0, 9'h000},  // 8  R6 ir15=1
    {4'b0000, 6'd8,  1'b1, 9'h077},  // 9
    {4'b0000, 6'd9,  1'b1, 9'h088},  // 10
    {4'b0000, 6'd10, 1'b0, 9'h000},  // 11 R6 ir14=0
    {4'b0000, 6'd11, 1'b1, 9'h0AA},  // 12
    {4'b0000, 6'd0,  1'b0, 9'h000},  // 13 R4 back to 0
    {4'b0000, 6'd1,  1'b1, 9'h0A5},  // 14
    {4'b0000, 6'd2,  1'b1, 9'h15A},  // 15
    {4'b0000, 6'd3,  1'b0, 9'h000},  // 16
    {4'b0000, 6'd4,  1'b1, 9'h111},  // 17
    {4'b0100, 6'd8,  1'b0, 9'h000},  // 18 R5 ac taken
    {4'b0000, 6'd9,  1'b1, 9'h088},  // 19
    {4'b0001, 6'd60, 1'b0, 9'h000},  // 20 R5 ir14 taken
    {4'b0000, 6'd61, 1'b1, 9'h13C},  // 21
    {4'b0000, 6'd62, 1'b1, 9'h13D},  // 22
    {4'b0000, 6'd63, 1'b1, 9'h13E},  // 23
    {4'b0000, 6'd0,  1'b1, 9'h13F},  // 24 R7 wrap
    {4'b0000, 6'd1,  1'b1, 9'h0A5},  // 25
    {4'b0000, 6'd2,  1'b1, 9'h15A},  // 26
    {4'b0000, 6'd3,  1'b0, 9'h000},  // 27
    {4'b0000, 6'd4,  1'b1, 9'h111},  // 28
    {4'b1011, 6'd5,  1'b0, 9'h000},  // 29 R5 others opposite
    {4'b0000, 6'd6,  1'b1, 9'h055},  // 30
    {4'b1101, 6'd10, 1'b0, 9'h000},  // 31 R5 ir15 taken
    {4'b0000, 6'd11, 1'b1, 9'h0AA},  // 32
    {4'b1000, 6'd12, 1'b0, 9'h000},  // 33 R6 wait=1
    {4'b0000, 6'd13, 1'b1, 9'h10C}   // 34
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wait_in = 1'b0;
  logic       ac_sign = 1'b0;
  logic [1:0] ir_op = 2'b00;
  logic       uop_valid;
  logic [8:0] uop_code;
  logic [5:0] upc;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  vms_sequencer #(.PROGRAM(PROG)) uut (
    .clk(clk), .rst(rst), .wait_in(wait_in), .ac_sign(ac_sign), .ir_op(ir_op),
    .uop_valid(uop_valid), .uop_code(uop_code), .upc(upc)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c);
    wait_in = c[3];
    ac_sign = c[2];
    ir_op   = c[1:0];
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 upc", upc, 0);
    check("R1 valid", uop_valid, 0);
    check("R1 code", uop_code, 0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19:16]);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R2/R4/R5/R6/R7/R8 step %0d upc", i), upc, VEC[i][15:10]);
      check($sformatf("R2/R3 step %0d valid", i), uop_valid, VEC[i][9]);
      check($sformatf("R2/R3 step %0d code", i), uop_code, VEC[i][8:0]);
    end
    // R1: reset in mid-program, then restart at address 0
    drive(4'b0000);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid upc", upc, 0);
    check("R1 mid valid", uop_valid, 0);
    check("R1 mid code", uop_code, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 restart upc", upc, 1);
    check("R1 restart code", uop_code, 9'h0A5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule